// File: doc/BRIEF.md
# Dual-Slot Status Word Commit Merger

This block finishes an instruction bundle by committing up to two queued, masked writes to the 32-bit processor status word. The writes come from the two execution slots of a bundle and are applied in issue order. Record 0 is always the earlier write and record 1 the later one. When both writes touch the same condition flags, the later write takes those flags and the earlier write's claim on them is dropped. A later overflow write also cancels the earlier write's accumulated-overflow update. The flag arbitration is bypassed when the first slot issued a move-to-system-register instruction.

After the writes, an optional trap rewrites the word. An ordinary trap saves the word to a backup register and keeps only the debug-enable and stack-mode bits. A debug trap saves the word to a debug copy register and leaves only the debug-state bit set. Whenever the word was written or a trap was taken, the active stack-pointer bank follows the stack-mode bit. When that bit changes, the live stack pointer is saved into the bank being left, and the other bank's saved value is handed back.

All state changes in the cycle that follows a `commit` strobe. Bits are named by an MSB-first index k, which maps to word bit 31-k. Defaults are: stack mode k=0, debug enable k=3, debug state k=4, flags F0..F3 k=17..20, S k=21, V k=22, VA k=23, C k=24.

Top module: `psw_commit_merge`

## Requirements
- R1: On commit, a valid write updates the word as (old & ~mask) | (value & mask). Bits outside the mask keep their value.
- R2: The flag set is F0, F1, F2, F3, S, V, VA and C (word bits 14, 13, 12, 11, 10, 9, 8, 7). When both writes are valid and their masks share any flag bit, the shared flag bits take the later write's value and the earlier write's value is dropped for them.
- R3: If such a flag overlap exists and the later mask contains V (bit 9), the earlier write's VA (bit 8) is not applied, even when VA is absent from the later mask. Without a flag overlap, VA from the earlier write is applied.
- R4: When `sys_move_first` is 1, no flag arbitration takes place. Both writes are applied whole, the earlier one first.
- R5: Writes are applied in issue order, so on overlapping non-flag bits the later write's value wins.
- R6: With `trap_code` 1 (ordinary trap), the backup copy receives the word after both writes. The new word keeps only debug enable (bit 28) and stack mode (bit 31).
- R7: With `trap_code` 2 (debug trap), the debug copy receives the word after both writes, and the new word is exactly 0x0800_0000 (debug state, bit 27). Codes 0 and 3 take no trap.
- R8: A commit that writes the word or takes a trap sets `sp_sel` to the new bit 31. When this changes `sp_sel`, `sp_swap` pulses for one cycle, `sp_live` is stored in the bank being left, and `sp_reload` shows the stored value of the bank being entered.
- R9: Synchronous active-high reset clears the word, both copies, both banks, `sp_sel`, `sp_swap` and `sp_reload`.
- R10: Without `commit`, no output changes. A commit with no valid write and no trap changes nothing and raises no `sp_swap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | End-of-bundle commit strobe |
| wr0_valid | input | 1 | Earlier write record present |
| wr0_mask | input | 32 | Earlier write bit mask |
| wr0_value | input | 32 | Earlier write data |
| wr1_valid | input | 1 | Later write record present |
| wr1_mask | input | 32 | Later write bit mask |
| wr1_value | input | 32 | Later write data |
| sys_move_first | input | 1 | First slot was a move-to-system-register |
| trap_code | input | 2 | 0 none, 1 ordinary, 2 debug, 3 none |
| sp_live | input | 32 | Current stack pointer value |
| psw | output | 32 | Committed status word |
| backup_psw | output | 32 | Copy saved by an ordinary trap |
| debug_psw | output | 32 | Copy saved by a debug trap |
| sp_sel | output | 1 | Active stack-pointer bank |
| sp_swap | output | 1 | One-cycle pulse on a bank change |
| sp_reload | output | 32 | Saved pointer of the bank just entered |

## Verification
The merge is driven with:
- a single write;
- two writes on disjoint and on overlapping non-flag bits, which shows that issue order decides;
- two writes that share a flag with and without V in the later mask, which separates per-bit flag arbitration from the V-implies-VA rule;
- a V-only later write against a VA-only earlier write, which shows that VA suppression needs a real flag overlap;
- the same pairs with the move-to-system-register flag set, which must apply both writes whole.

Traps are combined with same-cycle writes, so the saved copy is shown to be the merged word. The stack-mode bit is toggled by writes and traps, and returns to a bank whose saved pointer was written earlier.

// File: rtl/psw_merge_pkg.sv
package psw_merge_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_ORD  = 2'd1,
    TRAP_DBG  = 2'd2,
    TRAP_RSVD = 2'd3
  } trap_kind_e;

  // Masked merge of one queued write into a word.
  function automatic logic [WORD_W-1:0] masked_merge(input logic [WORD_W-1:0] old_w,
                                                      input logic [WORD_W-1:0] mask,
                                                      input logic [WORD_W-1:0] value);
    return (old_w & ~mask) | (value & mask);
  endfunction
endpackage

// File: rtl/psw_slot_filter.sv
module psw_slot_filter #(
  parameter int W = 32,
  parameter logic [W-1:0] FLAG_SET = '0,
  parameter logic [W-1:0] V_BIT = '0,
  parameter logic [W-1:0] VA_BIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr0_valid,
  input  logic [W-1:0] wr0_mask,
  input  logic         wr1_valid,
  input  logic [W-1:0] wr1_mask,
  input  logic         sys_move_first,
  output logic [W-1:0] wr0_mask_eff,
  output logic         contention
);
  logic [W-1:0] shared_flags;

  assign shared_flags = wr0_mask & wr1_mask & FLAG_SET;
  assign contention   = wr0_valid & wr1_valid & ~sys_move_first & (|shared_flags);

  always_comb begin
    wr0_mask_eff = wr0_valid ? wr0_mask : '0;
    if (contention) begin
      wr0_mask_eff = wr0_mask_eff & ~shared_flags;
      if (|(wr1_mask & V_BIT)) wr0_mask_eff = wr0_mask_eff & ~VA_BIT;
    end
  end

  // R2: arbitration only ever narrows the earlier mask
  a_r2_mask_subset: assert property (@(posedge clk) disable iff (rst)
    (wr0_mask_eff & ~wr0_mask) == '0);
  // R2: no flag claimed by the later write survives in the earlier mask
  a_r2_later_owns: assert property (@(posedge clk) disable iff (rst)
    contention |-> ((wr0_mask_eff & wr1_mask & FLAG_SET) == '0));
  // R3: later V cancels earlier VA under contention
  a_r3_va_cancel: assert property (@(posedge clk) disable iff (rst)
    (contention && (wr1_mask & V_BIT) != '0) |-> ((wr0_mask_eff & VA_BIT) == '0));
  // R4: move-to-system-register bypasses arbitration
  a_r4_bypass: assert property (@(posedge clk) disable iff (rst)
    sys_move_first |-> (!contention && wr0_mask_eff == (wr0_valid ? wr0_mask : '0)));
endmodule

// File: rtl/psw_trap_stage.sv
module psw_trap_stage #(
  parameter int W = 32,
  parameter logic [W-1:0] ORD_KEEP = '0,
  parameter logic [W-1:0] DS_BIT = '0
) (
  input  logic [W-1:0] word_in,
  input  logic [1:0]   trap_code,
  output logic [W-1:0] word_out,
  output logic         save_backup,
  output logic         save_debug
);
  import psw_merge_pkg::*;
  trap_kind_e kind;

  assign kind = trap_kind_e'(trap_code);

  always_comb begin
    word_out    = word_in;
    save_backup = 1'b0;
    save_debug  = 1'b0;
    unique case (kind)
      TRAP_ORD: begin
        word_out    = word_in & ORD_KEEP;
        save_backup = 1'b1;
      end
      TRAP_DBG: begin
        word_out   = DS_BIT;
        save_debug = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sp_bank_select.sv
module sp_bank_select #(
  parameter int W = 32,
  parameter int BANKS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         update,
  input  logic         sm_next,
  input  logic [W-1:0] sp_live,
  output logic         sp_sel,
  output logic         sp_swap,
  output logic [W-1:0] sp_reload
);
  logic [W-1:0] bank_q [BANKS];
  logic         swap_now;

  assign swap_now = update && (sm_next != sp_sel);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                   bank_q[b] <= '0;
      else if (swap_now && (int'(sp_sel) == b))  bank_q[b] <= sp_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_sel    <= 1'b0;
      sp_swap   <= 1'b0;
      sp_reload <= '0;
    end else begin
      sp_swap <= swap_now;
      if (swap_now) begin
        sp_sel    <= sm_next;
        sp_reload <= bank_q[sm_next];
      end
    end
  end

  // R8: a swap pulse always coincides with a bank change
  a_r8_swap_changes_bank: assert property (@(posedge clk) disable iff (rst)
    sp_swap |-> (sp_sel != $past(sp_sel)));
  // R8: the bank never changes without a swap pulse
  a_r8_no_silent_change: assert property (@(posedge clk) disable iff (rst)
    !sp_swap |-> $stable(sp_sel));
endmodule

// File: rtl/psw_commit_merge.sv
module psw_commit_merge #(
  parameter int W      = 32,
  parameter int SM_K   = 0,
  parameter int DB_K   = 3,
  parameter int DS_K   = 4,
  parameter int F0_K   = 17,
  parameter int F1_K   = 18,
  parameter int F2_K   = 19,
  parameter int F3_K   = 20,
  parameter int S_K    = 21,
  parameter int V_K    = 22,
  parameter int VA_K   = 23,
  parameter int C_K    = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic         wr0_valid,
  input  logic [W-1:0] wr0_mask,
  input  logic [W-1:0] wr0_value,
  input  logic         wr1_valid,
  input  logic [W-1:0] wr1_mask,
  input  logic [W-1:0] wr1_value,
  input  logic         sys_move_first,
  input  logic [1:0]   trap_code,
  input  logic [W-1:0] sp_live,
  output logic [W-1:0] psw,
  output logic [W-1:0] backup_psw,
  output logic [W-1:0] debug_psw,
  output logic         sp_sel,
  output logic         sp_swap,
  output logic [W-1:0] sp_reload
);
  import psw_merge_pkg::*;

  localparam logic [W-1:0] TOP1     = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SM_BIT   = TOP1 >> SM_K;
  localparam logic [W-1:0] DB_BIT   = TOP1 >> DB_K;
  localparam logic [W-1:0] DS_BIT   = TOP1 >> DS_K;
  localparam logic [W-1:0] V_BIT    = TOP1 >> V_K;
  localparam logic [W-1:0] VA_BIT   = TOP1 >> VA_K;
  localparam logic [W-1:0] FLAG_SET = (TOP1 >> F0_K) | (TOP1 >> F1_K) | (TOP1 >> F2_K) |
                                      (TOP1 >> F3_K) | (TOP1 >> S_K)  | V_BIT | VA_BIT |
                                      (TOP1 >> C_K);
  localparam logic [W-1:0] ORD_KEEP = DB_BIT | SM_BIT;
  localparam int SM_IDX = W - 1 - SM_K;

  logic [W-1:0] psw_q, backup_q, debug_q;
  logic [W-1:0] mask0_eff, after0, after1, psw_next;
  logic         contention, save_backup, save_debug, word_touched;

  psw_slot_filter #(.W(W), .FLAG_SET(FLAG_SET), .V_BIT(V_BIT), .VA_BIT(VA_BIT)) u_filter (
    .clk(clk), .rst(rst),
    .wr0_valid(wr0_valid), .wr0_mask(wr0_mask),
    .wr1_valid(wr1_valid), .wr1_mask(wr1_mask),
    .sys_move_first(sys_move_first),
    .wr0_mask_eff(mask0_eff), .contention(contention)
  );

  assign after0 = masked_merge(psw_q, mask0_eff, wr0_value);
  assign after1 = wr1_valid ? masked_merge(after0, wr1_mask, wr1_value) : after0;

  psw_trap_stage #(.W(W), .ORD_KEEP(ORD_KEEP), .DS_BIT(DS_BIT)) u_trap (
    .word_in(after1), .trap_code(trap_code), .word_out(psw_next),
    .save_backup(save_backup), .save_debug(save_debug)
  );

  assign word_touched = wr0_valid | wr1_valid | save_backup | save_debug;

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q    <= '0;
      backup_q <= '0;
      debug_q  <= '0;
    end else if (commit) begin
      psw_q <= psw_next;
      if (save_backup) backup_q <= after1;
      if (save_debug)  debug_q  <= after1;
    end
  end

  sp_bank_select #(.W(W), .BANKS(2)) u_sp (
    .clk(clk), .rst(rst), .update(commit && word_touched),
    .sm_next(psw_next[SM_IDX]), .sp_live(sp_live),
    .sp_sel(sp_sel), .sp_swap(sp_swap), .sp_reload(sp_reload)
  );

  assign psw        = psw_q;
  assign backup_psw = backup_q;
  assign debug_psw  = debug_q;

  // R6: ordinary trap leaves only debug enable and stack mode
  a_r6_ord_clear: assert property (@(posedge clk) disable iff (rst)
    (commit && trap_code == 2'd1) |=> ((psw & ~ORD_KEEP) == '0));
  // R7: debug trap leaves only debug state
  a_r7_dbg_only_ds: assert property (@(posedge clk) disable iff (rst)
    (commit && trap_code == 2'd2) |=> (psw == DS_BIT));
  // R10: no commit, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(psw) && $stable(backup_psw) && $stable(debug_psw) && !sp_swap));
  // R8: the active bank always matches the committed stack-mode bit
  a_r8_bank_matches_sm: assert property (@(posedge clk) disable iff (rst)
    sp_sel == psw[SM_IDX]);
  // R2: when arbitration fires, the later write's flags land as given
  a_r2_later_flags_land: assert property (@(posedge clk) disable iff (rst)
    (commit && contention && trap_code == 2'd0) |=>
      ((psw & $past(wr1_mask) & FLAG_SET) == ($past(wr1_value) & $past(wr1_mask) & FLAG_SET)));
endmodule

// File: tb/tb_psw_commit_merge.sv
`timescale 1ns/1ps
module tb_psw_commit_merge;
  logic        clk = 0, rst = 1, commit = 0;
  logic        wr0_valid = 0, wr1_valid = 0, sys_move_first = 0;
  logic [31:0] wr0_mask = 0, wr0_value = 0, wr1_mask = 0, wr1_value = 0, sp_live = 0;
  logic [1:0]  trap_code = 0;
  logic [31:0] psw, backup_psw, debug_psw, sp_reload;
  logic        sp_sel, sp_swap;

  int checks = 0, failures = 0;
  logic [31:0] exp_psw = 0, exp_bkp = 0, exp_dbg = 0;
  logic        exp_sel = 0;

  localparam logic [31:0] FLAGS = 32'h0000_7F80;
  localparam logic [31:0] F0 = 32'h4000, F1 = 32'h2000, S = 32'h0400, V = 32'h0200,
                          VA = 32'h0100, C = 32'h0080;

  always #4 clk = ~clk;

  psw_commit_merge dut (
    .clk(clk), .rst(rst), .commit(commit),
    .wr0_valid(wr0_valid), .wr0_mask(wr0_mask), .wr0_value(wr0_value),
    .wr1_valid(wr1_valid), .wr1_mask(wr1_mask), .wr1_value(wr1_value),
    .sys_move_first(sys_move_first), .trap_code(trap_code), .sp_live(sp_live),
    .psw(psw), .backup_psw(backup_psw), .debug_psw(debug_psw),
    .sp_sel(sp_sel), .sp_swap(sp_swap), .sp_reload(sp_reload)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Per-bit reference: later write wins its bits; earlier bits drop on flag contention.
  function automatic logic [31:0] model(input logic [31:0] old_w,
      input logic v0, input logic [31:0] m0, input logic [31:0] d0,
      input logic v1, input logic [31:0] m1, input logic [31:0] d1, input logic sys);
    logic [31:0] r;
    logic overlap;
    overlap = v0 && v1 && !sys && ((m0 & m1 & FLAGS) != 0);
    for (int b = 0; b < 32; b++) begin
      logic drop;
      drop = overlap && ((FLAGS[b] && m1[b]) || (b == 8 && m1[9]));
      r[b] = old_w[b];
      if (v0 && m0[b] && !drop) r[b] = d0[b];
      if (v1 && m1[b]) r[b] = d1[b];
    end
    return r;
  endfunction

  // One commit; compares all outputs with the reference afterwards.
  task automatic do_commit(input string tag, input logic v0, input logic [31:0] m0,
      input logic [31:0] d0, input logic v1, input logic [31:0] m1, input logic [31:0] d1,
      input logic sys, input logic [1:0] trap);
    logic [31:0] merged;
    logic exp_swap, new_sel;
    merged = model(exp_psw, v0, m0, d0, v1, m1, d1, sys);
    exp_psw = merged;
    if (trap == 2'd1) begin exp_bkp = merged; exp_psw = merged & 32'h9000_0000; end
    if (trap == 2'd2) begin exp_dbg = merged; exp_psw = 32'h0800_0000; end
    new_sel  = (v0 || v1 || trap == 2'd1 || trap == 2'd2) ? exp_psw[31] : exp_sel;
    exp_swap = new_sel != exp_sel;
    exp_sel  = new_sel;
    @(negedge clk);
    wr0_valid = v0; wr0_mask = m0; wr0_value = d0;
    wr1_valid = v1; wr1_mask = m1; wr1_value = d1;
    sys_move_first = sys; trap_code = trap; commit = 1;
    @(negedge clk);
    commit = 0; wr0_valid = 0; wr1_valid = 0; trap_code = 0; sys_move_first = 0;
    check({tag, " psw"}, psw, exp_psw);
    check({tag, " backup"}, backup_psw, exp_bkp);
    check({tag, " debug"}, debug_psw, exp_dbg);
    check({tag, " sp_sel"}, {31'd0, sp_sel}, {31'd0, exp_sel});
    check({tag, " sp_swap"}, {31'd0, sp_swap}, {31'd0, exp_swap});
  endtask

  task automatic t_reset;
    check("R9 psw", psw, 0);
    check("R9 backup", backup_psw, 0);
    check("R9 debug", debug_psw, 0);
    check("R9 sp", {30'd0, sp_sel, sp_swap}, 0);
    check("R9 reload", sp_reload, 0);
  endtask

  task automatic t_mask;
    do_commit("R1 single", 1, 32'h0000_FFFF, 32'hA5A5_A5A5, 0, 0, 0, 0, 0);
    check("R1 literal", psw, 32'h0000_A5A5);
    do_commit("R1 later only", 0, 0, 0, 1, 32'h00FF_0000, 32'h1234_5678, 0, 0);
    check("R1 literal2", psw, 32'h0034_A5A5);
  endtask

  task automatic t_order;
    do_commit("R5 order", 1, 32'h0000_0033, 32'h0000_0011, 1, 32'h0000_0030, 32'h0000_0020, 0, 0);
    check("R5 literal", psw & 32'h33, 32'h21);
  endtask

  task automatic t_conflict;
    do_commit("R2 clear", 1, FLAGS, 0, 0, 0, 0, 0, 0);
    do_commit("R2 shared F0", 1, F0 | F1 | VA, 32'hFFFF_FFFF, 1, F0, 0, 0, 0);
    check("R2 literal", psw & FLAGS, F1 | VA);
  endtask

  task automatic t_overflow;
    do_commit("R3 clear", 1, FLAGS, 0, 0, 0, 0, 0, 0);
    do_commit("R3 V drops VA", 1, F0 | VA | C, 32'hFFFF_FFFF, 1, F0 | V, 0, 0, 0);
    check("R3 literal", psw & FLAGS, C);
    do_commit("R3 no overlap", 1, VA, 32'hFFFF_FFFF, 1, V, 32'hFFFF_FFFF, 0, 0);
    check("R3 literal2", psw & (V | VA), V | VA);
  endtask

  task automatic t_sysmove;
    do_commit("R4 clear", 1, FLAGS, 0, 0, 0, 0, 0, 0);
    do_commit("R4 bypass", 1, F0 | VA | S, 32'hFFFF_FFFF, 1, F0 | V, 0, 1, 0);
    check("R4 literal", psw & FLAGS, VA | S);
  endtask

  task automatic t_traps;
    do_commit("R6 fill", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    do_commit("R6 ord trap", 0, 0, 0, 1, 32'h0000_00FF, 0, 0, 2'd1);
    check("R6 literal", psw, 32'h9000_0000);
    check("R6 backup literal", backup_psw, 32'hFFFF_FF00);
    do_commit("R7 dbg trap", 1, 32'h0000_0F00, 32'h0000_0500, 0, 0, 0, 0, 2'd2);
    check("R7 literal", psw, 32'h0800_0000);
    do_commit("R7 code3 none", 1, 32'h1, 32'h1, 0, 0, 0, 0, 2'd3);
  endtask

  task automatic t_sp;
    sp_live = 32'h0000_1000;
    do_commit("R8 enter bank1", 1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0);
    check("R8 reload bank1", sp_reload, 32'h0);
    sp_live = 32'h0000_2000;
    do_commit("R8 stay bank1", 1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0);
    do_commit("R8 back bank0", 1, 32'h8000_0000, 0, 0, 0, 0, 0, 0);
    check("R8 reload bank0", sp_reload, 32'h0000_1000);
    sp_live = 32'h0000_3000;
    do_commit("R8 bank1 again", 0, 0, 0, 1, 32'h8000_0000, 32'h8000_0000, 0, 0);
    check("R8 reload bank1 saved", sp_reload, 32'h0000_2000);
  endtask

  task automatic t_idle;
    @(negedge clk);
    wr0_valid = 1; wr0_mask = 32'hFFFF_FFFF; wr0_value = 32'h0; trap_code = 2'd1;
    @(negedge clk);
    @(negedge clk);
    wr0_valid = 0; trap_code = 0;
    check("R10 no commit psw", psw, exp_psw);
    check("R10 no commit backup", backup_psw, exp_bkp);
    do_commit("R10 empty commit", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_order();
    t_conflict();
    t_overflow();
    t_sysmove();
    t_traps();
    t_sp();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule